// File: doc/BRIEF.md
# Configuration-Word and Control-Register Access Unit

This unit sits next to a 64-bit processor pipeline and handles a small family of instructions that share one major/minor opcode pattern. The pipeline presents a 32-bit instruction word together with the two operand values it read from the register file. The unit tells the pipeline whether the word belongs to the family and which register indices to read. It then carries out the operation. There are five operations: a configuration-word read that any privilege level may perform, and 32-bit and 64-bit reads and writes of control registers that live in a dedicated IO address space.

A configuration read finishes in the cycle it is presented, on its own result port, and it never touches the bus. A control-register operation first passes a privilege gate. If coprocessor-0 access is disabled, the unit raises a coprocessor-unusable exception in the same cycle and issues nothing. Otherwise the unit latches a request and holds it on a valid/ready bus until the target accepts it. The request carries the address, the write data, a size flag, a direction flag and the issuing core's index. One cycle after acceptance, a read delivers its writeback on a second result port and a write pulses a completion flag. The whole family is recognised only while the extension-enable input is high.

Top module: `csr_access_unit`

## Requirements
- R1: `match_o` is 1 exactly when `ext_en_i` is 1, bits 31:26 of `insn_i` are 110010, bits 10:6 are 00100, bits 5:0 are 011000, and bits 20:16 hold one of the five operation codes of R2. Otherwise it is 0. `src_idx_o` is bits 25:21 and `dat_idx_o` is bits 15:11, shown combinationally.
- R2: Bits 20:16 select the operation: 01000 configuration read, 00000 32-bit read, 00001 32-bit write, 00010 64-bit read, 00011 64-bit write.
- R3: When `issue_valid_i` is 1 and the word matches as a configuration read, `cfg_wb_valid_o` is 1 in the same cycle. `cfg_wb_reg_o` equals bits 15:11. `cfg_wb_data_o` is `prid_i` for a `src_val_i` of 0, `cfg1_i` for 1, `cfg2_i` for 2, and zero for any other value. No bus request results.
- R4: A matching control-register operation issued while `cp0_en_i` is 0 and `busy_o` is 0 drives `excp_o` to 1 in that cycle. It starts no request: `busy_o` and `bus_req_valid_o` stay 0.
- R5: A matching control-register operation issued while `cp0_en_i` is 1 and `busy_o` is 0 raises `busy_o` and `bus_req_valid_o` from the next cycle. The request fields are held stable until the cycle `bus_ready_i` is 1:
  - `bus_addr_o` is the low AW bits of `src_val_i`.
  - `bus_write_o` is 1 for writes.
  - `bus_dbl_o` is 1 for 64-bit forms.
  - `bus_reqid_o` is `core_idx_i` as sampled at issue.
- R6: A 32-bit write drives `bus_wdata_o` with the low 32 bits of `dat_val_i` and zeros above. A 64-bit write drives all 64 bits of `dat_val_i`.
- R7: In the cycle after `bus_ready_i` is seen with a request pending, `busy_o` is 0 and one pulse lasting one cycle appears.
  - For a read, `csr_wb_valid_o` is 1, `csr_wb_reg_o` is bits 15:11 of the issued word, and `csr_wb_data_o` is `bus_rdata_i`. For a 32-bit read, bit 31 of `bus_rdata_i` is copied into bits 63:32.
  - For a write, `done_o` is 1 instead.
- R8: While `busy_o` is 1, a control-register operation presented on the inputs is ignored. `excp_o` stays 0 and the pending request is unchanged.
- R9: The configuration read needs no privilege. It completes with `cp0_en_i` at 0, and also while `busy_o` is 1, including the cycle in which the bus accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ext_en_i | input | 1 | Enables recognition of the instruction family |
| cp0_en_i | input | 1 | Coprocessor-0 access allowed |
| issue_valid_i | input | 1 | Instruction and operands are valid this cycle |
| insn_i | input | 32 | Instruction word |
| src_val_i | input | 64 | Operand from the source register (index or address) |
| dat_val_i | input | 64 | Operand from the data register (write data) |
| core_idx_i | input | ID_W | Index of this core |
| prid_i | input | 64 | Processor identification word |
| cfg1_i | input | 64 | Configuration word 1 |
| cfg2_i | input | 64 | Configuration word 2 |
| match_o | output | 1 | Word belongs to the family |
| src_idx_o | output | 5 | Source register index |
| dat_idx_o | output | 5 | Destination or data register index |
| excp_o | output | 1 | Coprocessor-unusable exception |
| cfg_wb_valid_o | output | 1 | Configuration result valid |
| cfg_wb_reg_o | output | 5 | Configuration result register |
| cfg_wb_data_o | output | 64 | Configuration result value |
| busy_o | output | 1 | Control-register request pending |
| bus_req_valid_o | output | 1 | Bus request valid |
| bus_ready_i | input | 1 | Bus accepts the request |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 64 | Bus write data |
| bus_dbl_o | output | 1 | 1 = 64-bit transfer, 0 = 32-bit |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_reqid_o | output | ID_W | Requester identity |
| bus_rdata_i | input | 64 | Read data, valid with bus_ready_i |
| csr_wb_valid_o | output | 1 | Control-register read result valid |
| csr_wb_reg_o | output | 5 | Control-register read result register |
| csr_wb_data_o | output | 64 | Control-register read result value |
| done_o | output | 1 | Control-register write completed |

## Verification
A configuration read may complete in the same cycle that the bus accepts a pending control-register request, because the two results leave on separate ports. The bench provokes this by presenting a configuration read, with privilege off, in exactly the cycle it raises `bus_ready_i`. It then checks the configuration result in that cycle and the bus result in the next, each against its own expected value. A privileged-operation attempt with privilege off is also injected while a request is pending, to confirm that no exception appears and that the held request fields do not move.

// File: rtl/csru_pkg.sv
package csru_pkg;

    localparam int XLEN = 64;

    localparam logic [5:0] MAJOR_OPC = 6'b110010;
    localparam logic [4:0] MID_FIELD = 5'b00100;
    localparam logic [5:0] MINOR_OPC = 6'b011000;

    localparam logic [4:0] SEL_CFG  = 5'b01000;
    localparam logic [4:0] SEL_RD32 = 5'b00000;
    localparam logic [4:0] SEL_WR32 = 5'b00001;
    localparam logic [4:0] SEL_RD64 = 5'b00010;
    localparam logic [4:0] SEL_WR64 = 5'b00011;

    typedef enum logic [2:0] {
        CSRU_NONE,
        CSRU_CFG,
        CSRU_RD32,
        CSRU_WR32,
        CSRU_RD64,
        CSRU_WR64
    } csru_op_e;

    typedef struct packed {
        csru_op_e   op;
        logic [4:0] src_reg;
        logic [4:0] dst_reg;
    } csru_dec_t;

    function automatic logic op_is_csr(csru_op_e op);
        return (op == CSRU_RD32) || (op == CSRU_WR32) ||
               (op == CSRU_RD64) || (op == CSRU_WR64);
    endfunction

    function automatic logic op_is_write(csru_op_e op);
        return (op == CSRU_WR32) || (op == CSRU_WR64);
    endfunction

    function automatic logic op_is_dbl(csru_op_e op);
        return (op == CSRU_RD64) || (op == CSRU_WR64);
    endfunction

    function automatic logic [XLEN-1:0] sext_word(logic [31:0] w);
        return {{(XLEN-32){w[31]}}, w};
    endfunction

endpackage

// File: rtl/csru_decode.sv
module csru_decode
    import csru_pkg::*;
(
    input  logic      ext_en_i,
    input  logic [31:0] insn_i,
    output csru_dec_t dec_o
);
    logic frame_ok;

    always_comb begin
        frame_ok = ext_en_i &&
                   (insn_i[31:26] == MAJOR_OPC) &&
                   (insn_i[10:6]  == MID_FIELD) &&
                   (insn_i[5:0]   == MINOR_OPC);
        dec_o.src_reg = insn_i[25:21];
        dec_o.dst_reg = insn_i[15:11];
        dec_o.op      = CSRU_NONE;
        if (frame_ok) begin
            case (insn_i[20:16])
                SEL_CFG:  dec_o.op = CSRU_CFG;
                SEL_RD32: dec_o.op = CSRU_RD32;
                SEL_WR32: dec_o.op = CSRU_WR32;
                SEL_RD64: dec_o.op = CSRU_RD64;
                SEL_WR64: dec_o.op = CSRU_WR64;
                default:  dec_o.op = CSRU_NONE;
            endcase
        end
    end

    always_comb begin
        if (ext_en_i == 1'b0) begin
            AST_DISABLED_NO_OP: assert (dec_o.op == CSRU_NONE); // R1
        end
    end

endmodule

// File: rtl/csru_cfg_lookup.sv
module csru_cfg_lookup
    import csru_pkg::*;
#(
    parameter int NWORDS = 3
)(
    input  logic [XLEN-1:0] index_i,
    input  logic [XLEN-1:0] words_i [NWORDS],
    output logic [XLEN-1:0] word_o
);
    always_comb begin
        word_o = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (index_i == XLEN'(i)) begin
                word_o = words_i[i];
            end
        end
    end

endmodule

// File: rtl/csru_bus_seq.sv
module csru_bus_seq
    import csru_pkg::*;
#(
    parameter int AW   = 32,
    parameter int ID_W = 8
)(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            issue_valid_i,
    input  logic            cp0_en_i,
    input  csru_dec_t       dec_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [XLEN-1:0] dat_val_i,
    input  logic [ID_W-1:0] core_idx_i,
    output logic            excp_o,
    output logic            busy_o,
    output logic            bus_req_valid_o,
    input  logic            bus_ready_i,
    output logic [AW-1:0]   bus_addr_o,
    output logic [XLEN-1:0] bus_wdata_o,
    output logic            bus_dbl_o,
    output logic            bus_write_o,
    output logic [ID_W-1:0] bus_reqid_o,
    input  logic [XLEN-1:0] bus_rdata_i,
    output logic            csr_wb_valid_o,
    output logic [4:0]      csr_wb_reg_o,
    output logic [XLEN-1:0] csr_wb_data_o,
    output logic            done_o
);
    typedef struct packed {
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] wdata;
        logic            dbl;
        logic            write;
        logic [ID_W-1:0] reqid;
        logic [4:0]      dst;
    } pend_t;

    pend_t           pend_q;
    logic            busy_q;
    logic            wb_q;
    logic            done_q;
    logic [4:0]      wb_reg_q;
    logic [XLEN-1:0] wb_data_q;
    logic            is_csr;
    logic            accept;
    logic            retire;
    logic [XLEN-1:0] wdata_new;

    always_comb begin
        is_csr    = issue_valid_i && op_is_csr(dec_i.op) && !busy_q;
        accept    = is_csr && cp0_en_i;
        excp_o    = is_csr && !cp0_en_i;
        retire    = busy_q && bus_ready_i;
        wdata_new = op_is_dbl(dec_i.op) ? dat_val_i
                                        : {{(XLEN-32){1'b0}}, dat_val_i[31:0]};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            busy_q    <= 1'b0;
            pend_q    <= '0;
            wb_q      <= 1'b0;
            done_q    <= 1'b0;
            wb_reg_q  <= '0;
            wb_data_q <= '0;
        end else begin
            wb_q   <= 1'b0;
            done_q <= 1'b0;
            if (accept) begin
                busy_q       <= 1'b1;
                pend_q.addr  <= addr_i;
                pend_q.wdata <= wdata_new;
                pend_q.dbl   <= op_is_dbl(dec_i.op);
                pend_q.write <= op_is_write(dec_i.op);
                pend_q.reqid <= core_idx_i;
                pend_q.dst   <= dec_i.dst_reg;
            end else if (retire) begin
                busy_q <= 1'b0;
                if (pend_q.write) begin
                    done_q <= 1'b1;
                end else begin
                    wb_q      <= 1'b1;
                    wb_reg_q  <= pend_q.dst;
                    wb_data_q <= pend_q.dbl ? bus_rdata_i : sext_word(bus_rdata_i[31:0]);
                end
            end
        end
    end

    assign busy_o          = busy_q;
    assign bus_req_valid_o = busy_q;
    assign bus_addr_o      = pend_q.addr;
    assign bus_wdata_o     = pend_q.wdata;
    assign bus_dbl_o       = pend_q.dbl;
    assign bus_write_o     = pend_q.write;
    assign bus_reqid_o     = pend_q.reqid;
    assign csr_wb_valid_o  = wb_q;
    assign csr_wb_reg_o    = wb_reg_q;
    assign csr_wb_data_o   = wb_data_q;
    assign done_o          = done_q;

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_req_valid_o && !bus_ready_i |=> bus_req_valid_o && $stable(bus_addr_o) &&
        $stable(bus_wdata_o) && $stable(bus_dbl_o) && $stable(bus_write_o) &&
        $stable(bus_reqid_o)); // R5

    AST_EXCP_NO_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        excp_o |=> !bus_req_valid_o); // R4

    AST_RD_RETIRE: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_req_valid_o && bus_ready_i && !bus_write_o |=> csr_wb_valid_o && !busy_o && !done_o); // R7

    AST_WR_RETIRE: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_req_valid_o && bus_ready_i && bus_write_o |=> done_o && !busy_o && !csr_wb_valid_o); // R7

    AST_BUSY_NO_EXCP: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_o |-> !excp_o); // R8

    AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        csr_wb_valid_o || done_o |=> !csr_wb_valid_o && !done_o); // R7

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csru_pkg::*;
#(
    parameter int AW   = 32,
    parameter int ID_W = 8
)(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            ext_en_i,
    input  logic            cp0_en_i,
    input  logic            issue_valid_i,
    input  logic [31:0]     insn_i,
    input  logic [63:0]     src_val_i,
    input  logic [63:0]     dat_val_i,
    input  logic [ID_W-1:0] core_idx_i,
    input  logic [63:0]     prid_i,
    input  logic [63:0]     cfg1_i,
    input  logic [63:0]     cfg2_i,
    output logic            match_o,
    output logic [4:0]      src_idx_o,
    output logic [4:0]      dat_idx_o,
    output logic            excp_o,
    output logic            cfg_wb_valid_o,
    output logic [4:0]      cfg_wb_reg_o,
    output logic [63:0]     cfg_wb_data_o,
    output logic            busy_o,
    output logic            bus_req_valid_o,
    input  logic            bus_ready_i,
    output logic [AW-1:0]   bus_addr_o,
    output logic [63:0]     bus_wdata_o,
    output logic            bus_dbl_o,
    output logic            bus_write_o,
    output logic [ID_W-1:0] bus_reqid_o,
    input  logic [63:0]     bus_rdata_i,
    output logic            csr_wb_valid_o,
    output logic [4:0]      csr_wb_reg_o,
    output logic [63:0]     csr_wb_data_o,
    output logic            done_o
);
    localparam int NWORDS = 3;

    csru_dec_t       dec;
    logic [XLEN-1:0] cfg_words [NWORDS];
    logic [XLEN-1:0] cfg_word;

    assign cfg_words[0] = prid_i;
    assign cfg_words[1] = cfg1_i;
    assign cfg_words[2] = cfg2_i;

    csru_decode u_dec (
        .ext_en_i (ext_en_i),
        .insn_i   (insn_i),
        .dec_o    (dec)
    );

    csru_cfg_lookup #(.NWORDS(NWORDS)) u_cfg (
        .index_i (src_val_i),
        .words_i (cfg_words),
        .word_o  (cfg_word)
    );

    csru_bus_seq #(.AW(AW), .ID_W(ID_W)) u_seq (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .issue_valid_i   (issue_valid_i),
        .cp0_en_i        (cp0_en_i),
        .dec_i           (dec),
        .addr_i          (src_val_i[AW-1:0]),
        .dat_val_i       (dat_val_i),
        .core_idx_i      (core_idx_i),
        .excp_o          (excp_o),
        .busy_o          (busy_o),
        .bus_req_valid_o (bus_req_valid_o),
        .bus_ready_i     (bus_ready_i),
        .bus_addr_o      (bus_addr_o),
        .bus_wdata_o     (bus_wdata_o),
        .bus_dbl_o       (bus_dbl_o),
        .bus_write_o     (bus_write_o),
        .bus_reqid_o     (bus_reqid_o),
        .bus_rdata_i     (bus_rdata_i),
        .csr_wb_valid_o  (csr_wb_valid_o),
        .csr_wb_reg_o    (csr_wb_reg_o),
        .csr_wb_data_o   (csr_wb_data_o),
        .done_o          (done_o)
    );

    assign match_o        = (dec.op != CSRU_NONE);
    assign src_idx_o      = dec.src_reg;
    assign dat_idx_o      = dec.dst_reg;
    assign cfg_wb_valid_o = issue_valid_i && (dec.op == CSRU_CFG);
    assign cfg_wb_reg_o   = dec.dst_reg;
    assign cfg_wb_data_o  = cfg_word;

    always_comb begin
        if (cfg_wb_valid_o && src_val_i == 64'd1) begin
            AST_CFG_WORD1: assert (cfg_wb_data_o == cfg1_i); // R3
        end
        if (cfg_wb_valid_o) begin
            AST_CFG_NO_EXCP: assert (!excp_o); // R9
        end
    end

endmodule

// File: tb/csr_access_unit_tb_top.sv
module csr_access_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int ID_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_en = 1'b0, cp0_en = 1'b0, issue = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] src_val = '0, dat_val = '0;
    logic [ID_W-1:0] core_idx = '0;
    logic [63:0] prid = 64'h0000_0000_0014_C001;
    logic [63:0] cfg1 = 64'hA5A5_0000_1234_5678;
    logic [63:0] cfg2 = 64'h0F0F_F0F0_DEAD_BEEF;
    logic match, excp, cfg_v, busy, req_v, ready = 1'b0, dbl, wr, csr_v, done;
    logic [4:0] sidx, didx, cfg_reg, csr_reg;
    logic [63:0] cfg_data, wdata, rdata = '0, csr_data;
    logic [AW-1:0] addr;
    logic [ID_W-1:0] reqid;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_access_unit #(.AW(AW), .ID_W(ID_W)) dut_i (
        .clk_i(clk), .rst_i(rst), .ext_en_i(ext_en), .cp0_en_i(cp0_en),
        .issue_valid_i(issue), .insn_i(insn), .src_val_i(src_val), .dat_val_i(dat_val),
        .core_idx_i(core_idx), .prid_i(prid), .cfg1_i(cfg1), .cfg2_i(cfg2),
        .match_o(match), .src_idx_o(sidx), .dat_idx_o(didx), .excp_o(excp),
        .cfg_wb_valid_o(cfg_v), .cfg_wb_reg_o(cfg_reg), .cfg_wb_data_o(cfg_data),
        .busy_o(busy), .bus_req_valid_o(req_v), .bus_ready_i(ready),
        .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_dbl_o(dbl), .bus_write_o(wr),
        .bus_reqid_o(reqid), .bus_rdata_i(rdata), .csr_wb_valid_o(csr_v),
        .csr_wb_reg_o(csr_reg), .csr_wb_data_o(csr_data), .done_o(done)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_insn(input logic [4:0] sel, input logic [4:0] rs, input logic [4:0] rd);
        return {6'b110010, rs, sel, rd, 5'b00100, 6'b011000};
    endfunction

    function automatic logic exp_match(input logic [31:0] w, input logic en);
        logic sel_ok;
        sel_ok = (w[20:16] == 5'b01000) || (w[20:16] == 5'b00000) || (w[20:16] == 5'b00001) ||
                 (w[20:16] == 5'b00010) || (w[20:16] == 5'b00011);
        return en && (w[31:26] == 6'b110010) && (w[10:6] == 5'b00100) &&
               (w[5:0] == 6'b011000) && sel_ok;
    endfunction

    function automatic logic [63:0] exp_cfg(input logic [63:0] idx);
        if (idx == 64'd0) return prid;
        if (idx == 64'd1) return cfg1;
        if (idx == 64'd2) return cfg2;
        return 64'd0;
    endfunction

    function automatic logic [4:0] sel_code(input int k);
        case (k)
            0: return 5'b00000;
            1: return 5'b00001;
            2: return 5'b00010;
            3: return 5'b00011;
            default: return 5'b01000;
        endcase
    endfunction

    task automatic check_word(input logic [31:0] w, input logic en);
        @(negedge clk);
        insn = w; ext_en = en; issue = 1'b0;
        #1;
        chk(match == exp_match(w, en), "R1 match", {63'd0, match}, {63'd0, exp_match(w, en)});
        chk(sidx == w[25:21] && didx == w[15:11], "R1 indices", {54'd0, sidx, didx}, {54'd0, w[25:21], w[15:11]});
    endtask

    task automatic run_cfg(input logic [63:0] idx, input logic [4:0] rd, input logic cp);
        @(negedge clk);
        insn = mk_insn(5'b01000, 5'd7, rd); src_val = idx; cp0_en = cp; issue = 1'b1;
        #1;
        chk(cfg_v == 1'b1 && match == 1'b1, "R2 cfg select", {62'd0, cfg_v, match}, 64'd3);
        chk(cfg_reg == rd, "R3 cfg reg", {59'd0, cfg_reg}, {59'd0, rd});
        chk(cfg_data == exp_cfg(idx), "R3 cfg data", cfg_data, exp_cfg(idx));
        chk(excp == 1'b0, "R9 cfg no excp", {63'd0, excp}, 64'd0);
        @(negedge clk);
        issue = 1'b0; insn = '0;
        chk(busy == 1'b0 && req_v == 1'b0, "R3 cfg no bus", {62'd0, busy, req_v}, 64'd0);
    endtask

    task automatic run_csr(input int k, input logic [63:0] a, input logic [63:0] d,
                           input logic [4:0] rd, input logic cp, input int delay,
                           input logic [63:0] rsp, input logic collide);
        logic [4:0] sel;
        logic is_wr, is_dbl;
        logic [ID_W-1:0] id_at_issue;
        logic [63:0] exp_wd, exp_rd;
        sel = sel_code(k);
        is_wr = (k == 1) || (k == 3);
        is_dbl = (k == 2) || (k == 3);
        exp_wd = is_dbl ? d : {32'd0, d[31:0]};
        exp_rd = is_dbl ? rsp : {{32{rsp[31]}}, rsp[31:0]};
        @(negedge clk);
        core_idx = ID_W'($urandom);
        id_at_issue = core_idx;
        insn = mk_insn(sel, 5'd3, rd); src_val = a; dat_val = d; cp0_en = cp; issue = 1'b1;
        #1;
        chk(match == 1'b1, "R2 csr select", {63'd0, match}, 64'd1);
        chk(excp == !cp, "R4 excp", {63'd0, excp}, {63'd0, !cp});
        @(negedge clk);
        issue = 1'b0; insn = '0; core_idx = ~id_at_issue; src_val = ~a; dat_val = ~d;
        if (!cp) begin
            chk(busy == 1'b0 && req_v == 1'b0, "R4 no request", {62'd0, busy, req_v}, 64'd0);
            return;
        end
        chk(busy == 1'b1 && req_v == 1'b1, "R5 request up", {62'd0, busy, req_v}, 64'd3);
        chk(addr == a[AW-1:0], "R5 addr", {32'd0, addr}, {32'd0, a[AW-1:0]});
        chk(wr == is_wr && dbl == is_dbl, "R5 flags", {62'd0, wr, dbl}, {62'd0, is_wr, is_dbl});
        chk(reqid == id_at_issue, "R5 reqid", {56'd0, reqid}, {56'd0, id_at_issue});
        if (is_wr) chk(wdata == exp_wd, "R6 wdata", wdata, exp_wd);
        for (int i = 0; i < delay; i++) begin
            if (i == 0) begin
                insn = mk_insn(5'b00001, 5'd9, 5'd9); cp0_en = 1'b0; issue = 1'b1;
                #1;
                chk(excp == 1'b0, "R8 ignored excp", {63'd0, excp}, 64'd0);
            end
            @(negedge clk);
            issue = 1'b0; insn = '0;
            chk(req_v == 1'b1 && addr == a[AW-1:0] && reqid == id_at_issue,
                "R8 request held", {32'd0, addr}, {32'd0, a[AW-1:0]});
        end
        ready = 1'b1; rdata = rsp;
        if (collide) begin
            insn = mk_insn(5'b01000, 5'd1, 5'd17); src_val = 64'd2; cp0_en = 1'b0; issue = 1'b1;
            #1;
            chk(cfg_v == 1'b1 && cfg_data == cfg2 && cfg_reg == 5'd17, "R9 cfg during busy",
                cfg_data, cfg2);
        end
        @(negedge clk);
        ready = 1'b0; issue = 1'b0; insn = '0; rdata = ~rsp;
        chk(busy == 1'b0 && req_v == 1'b0, "R7 busy drop", {62'd0, busy, req_v}, 64'd0);
        if (is_wr) begin
            chk(done == 1'b1 && csr_v == 1'b0, "R7 done", {62'd0, done, csr_v}, 64'd2);
        end else begin
            chk(csr_v == 1'b1 && done == 1'b0, "R7 wb valid", {62'd0, csr_v, done}, 64'd2);
            chk(csr_reg == rd, "R7 wb reg", {59'd0, csr_reg}, {59'd0, rd});
            chk(csr_data == exp_rd, "R7 wb data", csr_data, exp_rd);
        end
        @(negedge clk);
        chk(csr_v == 1'b0 && done == 1'b0, "R7 pulse ends", {62'd0, csr_v, done}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(busy == 0 && req_v == 0 && csr_v == 0 && done == 0, "R5 reset idle",
            {60'd0, busy, req_v, csr_v, done}, 64'd0);

        check_word(mk_insn(5'b01000, 5'd4, 5'd5), 1'b0);
        check_word(mk_insn(5'b00100, 5'd4, 5'd5), 1'b1);
        check_word(mk_insn(5'b00011, 5'd31, 5'd1), 1'b1);
        check_word(mk_insn(5'b00000, 5'd2, 5'd6) ^ 32'h0000_0040, 1'b1);
        check_word(mk_insn(5'b00000, 5'd2, 5'd6) ^ 32'h0400_0000, 1'b1);
        for (int i = 0; i < 60; i++) begin
            logic [31:0] w;
            w = (i % 2 == 0) ? $urandom : (mk_insn(5'($urandom), 5'($urandom), 5'($urandom)) ^ (32'd1 << ($urandom % 32)));
            check_word(w, 1'b1);
        end
        ext_en = 1'b1;

        run_cfg(64'd0, 5'd2, 1'b1);
        run_cfg(64'd1, 5'd3, 1'b0);
        run_cfg(64'd2, 5'd4, 1'b0);
        run_cfg(64'd3, 5'd5, 1'b1);
        run_cfg(64'h1_0000_0000, 5'd6, 1'b0);

        run_csr(0, 64'h0000_0000_0000_1008, 64'd0, 5'd8, 1'b1, 2, 64'h1234_5678_8000_0001, 1'b0);
        run_csr(0, 64'h20, 64'd0, 5'd9, 1'b1, 0, 64'hFFFF_FFFF_7FFF_FFFF, 1'b1);
        run_csr(2, 64'hFFFF_0000_0000_0420, 64'd0, 5'd10, 1'b1, 3, 64'h8000_0000_0000_0001, 1'b1);
        run_csr(1, 64'h30, 64'hDEAD_BEEF_CAFE_F00D, 5'd11, 1'b1, 1, 64'd0, 1'b0);
        run_csr(3, 64'h38, 64'hDEAD_BEEF_CAFE_F00D, 5'd12, 1'b1, 0, 64'd0, 1'b1);
        run_csr(1, 64'h40, 64'h1, 5'd13, 1'b0, 0, 64'd0, 1'b0);
        run_csr(2, 64'h48, 64'h1, 5'd14, 1'b0, 0, 64'd0, 1'b0);

        for (int i = 0; i < 40; i++) begin
            int k;
            k = int'($urandom % 5);
            if (k == 4) begin
                run_cfg(($urandom % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 5),
                        5'($urandom), 1'($urandom));
            end else begin
                run_csr(k, {$urandom, $urandom}, {$urandom, $urandom}, 5'($urandom),
                        ($urandom % 4) != 0, int'($urandom % 4), {$urandom, $urandom},
                        1'($urandom));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule